// File: doc/BRIEF.md
# Selectable Pulse-Width Debounce Filter

This block cleans up a buffered pulse line before it reaches a pulse counter. It runs from a slow sampling clock of roughly 8 kHz. Any input level that does not stay put for a fixed qualification time is removed. That time defaults to 14 clock cycles, or 1.75 ms at a 125 µs period. Rejection works on both levels: short high spikes are removed, and so are short low dropouts inside a long high pulse.

The raw input first passes through a synchroniser. It then feeds two paths: a stability filter, and a bypass that carries the synchronised level unchanged. A run-time select picks which path drives the registered output. With the select high, the output is filtered, and the filter limits the pulse rate it can pass. With the select low, the output carries the raw input after synchronisation, with no rate limit beyond one level change per clock. Changing the select does not disturb the filter's own timing.

Top module: `pulse_qualifier`

## Requirements
- R1: While reset is high, the output, the filtered level and the stability count are forced low on each clock edge. After reset, the output stays low until the input qualifies.
- R2: The raw input passes through a two-stage synchroniser. In bypass mode (select low), the output takes each new raw level exactly three clock edges after the raw change.
- R3: With `debounce_en` high, the output is driven from the filtered level. With it low, the output is driven from the synchronised raw level. A change of the select shows at the output on the next clock edge.
- R4: In filtered mode, a raw level held for at least QUAL_CYCLES clock cycles reaches the output QUAL_CYCLES+3 edges after the raw change.
- R5: In filtered mode, a raw level held for QUAL_CYCLES-1 cycles or fewer never reaches the output. This holds for high pulses on a low output and for low dropouts on a high output.
- R6: The stability count restarts whenever the sampled input returns to the current filtered level. Short pulses separated by brief gaps therefore never add up to a qualification.
- R7: A filtered pulse whose high and low phases each last at least QUAL_CYCLES keeps its width: both of its edges are delayed by the same QUAL_CYCLES+3 edges. A repetitive square wave of that kind passes intact.
- R8: In bypass mode, a high pulse one clock cycle wide reaches the output as a one-cycle pulse.
- R9: Switching the select does not clear or restart the filter. A qualification in progress when the output is switched away and back completes at the same edge as if no switch had happened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow sampling clock (about 8 kHz) |
| rst | input | 1 | Synchronous active-high reset |
| pulse_raw | input | 1 | Buffered, asynchronous pulse input |
| debounce_en | input | 1 | 1 selects the filtered path, 0 selects the bypass path |
| pulse_out | output | 1 | Registered conditioned pulse to the counter |

## Verification
The bench drives pulses exactly QUAL_CYCLES and QUAL_CYCLES-1 cycles wide. A filter that is off by one either passes the short pulse or drops the long one, and it shifts every edge by a cycle. Low dropouts inside a long high pulse catch a filter that only qualifies rising edges. Bursts of short pulses with two-cycle gaps catch a counter that is never cleared, because such a counter would let the burst through. Switching the select away and back during a qualification catches a design that resets the filter on a mode change: its rising edge would come late. One-cycle pulses in bypass expose any filtering or extra register left in the raw path.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic {
    PQ_BYPASS = 1'b0,
    PQ_FILTER = 1'b1
  } pq_mode_e;
endpackage

// File: rtl/pq_sync.sv
module pq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic ff;
    logic nxt;
    if (i == 0) begin : g_first
      assign nxt = d;
    end else begin : g_next
      assign nxt = g_stage[i-1].ff;
    end
    always_ff @(posedge clk) begin
      if (rst) ff <= 1'b0;
      else     ff <= nxt;
    end
  end

  assign q = g_stage[STAGES-1].ff;
endmodule

// File: rtl/pq_stability_timer.sv
module pq_stability_timer #(
  parameter int QUAL_CYCLES = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic smp,
  output logic lvl
);
  localparam int CW = (QUAL_CYCLES < 2) ? 1 : $clog2(QUAL_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (smp == lvl) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      lvl <= smp;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pq_out_select.sv
module pq_out_select
  import pq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pq_mode_e mode,
  input  logic     raw_s,
  input  logic     filt,
  output logic     q
);
  always_ff @(posedge clk) begin
    if (rst)                    q <= 1'b0;
    else if (mode == PQ_FILTER) q <= filt;
    else                        q <= raw_s;
  end
endmodule

// File: rtl/pulse_qualifier.sv
module pulse_qualifier
  import pq_pkg::*;
#(
  parameter int QUAL_CYCLES = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_raw,
  input  logic debounce_en,
  output logic pulse_out
);
  logic     synced_lvl;
  logic     filt_lvl;
  pq_mode_e mode;

  assign mode = pq_mode_e'(debounce_en);

  pq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pulse_raw),
    .q   (synced_lvl)
  );

  pq_stability_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
    .clk (clk),
    .rst (rst),
    .smp (synced_lvl),
    .lvl (filt_lvl)
  );

  pq_out_select u_sel (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .raw_s (synced_lvl),
    .filt  (filt_lvl),
    .q     (pulse_out)
  );
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int QUAL_CYCLES = 14,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic pulse_raw,
  input logic debounce_en,
  input logic pulse_out,
  input logic synced_lvl,
  input logic filt_lvl
);
  localparam int RW = $clog2(QUAL_CYCLES + 1);
  localparam logic [RW-1:0] LASTC = RW'(QUAL_CYCLES - 1);

  logic [RW-1:0] run;
  logic [3:0]    since;
  logic          rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      run   <= '0;
      since <= '0;
    end else begin
      if (since != 4'hF) since <= since + 4'd1;
      if (synced_lvl == filt_lvl) run <= '0;
      else if (run == LASTC)      run <= '0;
      else                        run <= run + 1'b1;
    end
  end

  // R1: one edge after a reset cycle the output is low
  always @(posedge clk) begin
    if (rst_q) a_r1_reset_clears: assert (pulse_out == 1'b0);
  end

  a_r2_sync_chain: assert property (@(posedge clk) disable iff (rst)
    (since >= 4'(SYNC_STAGES)) |-> synced_lvl == $past(pulse_raw, SYNC_STAGES));

  a_r3_filter_path: assert property (@(posedge clk) disable iff (rst)
    debounce_en |=> pulse_out == $past(filt_lvl));

  a_r3_bypass_path: assert property (@(posedge clk) disable iff (rst)
    !debounce_en |=> pulse_out == $past(synced_lvl));

  a_r4_flip_on_qual: assert property (@(posedge clk) disable iff (rst)
    (synced_lvl != filt_lvl && run == LASTC) |=> filt_lvl == $past(synced_lvl));

  a_r5_hold_without_qual: assert property (@(posedge clk) disable iff (rst)
    (synced_lvl == filt_lvl || run != LASTC) |=> $stable(filt_lvl));
endmodule

bind pulse_qualifier pq_checker #(
  .QUAL_CYCLES(QUAL_CYCLES),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pulse_raw   (pulse_raw),
  .debounce_en (debounce_en),
  .pulse_out   (pulse_out),
  .synced_lvl  (synced_lvl),
  .filt_lvl    (filt_lvl)
);

// File: tb/sim_pulse_qualifier.sv
`timescale 1ns/1ps
module sim_pulse_qualifier;
  localparam int Q = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_raw = 1'b0;
  logic debounce_en = 1'b1;
  logic pulse_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic prev_out = 1'b0;

  typedef struct {
    int    at;
    bit    lvl;
    string req;
  } ev_t;
  ev_t exp_q[$];

  pulse_qualifier #(.QUAL_CYCLES(Q), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .pulse_raw(pulse_raw),
    .debounce_en(debounce_en), .pulse_out(pulse_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(int at, bit lvl, string req);
    ev_t e;
    e.at = at; e.lvl = lvl; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: every output change must match the head of the queue
  always @(negedge clk) begin
    if (rst) begin
      prev_out = pulse_out;
    end else if (pulse_out !== prev_out) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected-edge", int'(pulse_out), int'(prev_out));
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(e.at == cyc, e.req, cyc, e.at);
        chk(e.lvl == pulse_out, e.req, int'(pulse_out), int'(e.lvl));
      end
      prev_out = pulse_out;
    end
  end

  task automatic step(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic drained(string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // filtered-mode pulse: high for w cycles, then low for gap cycles
  task automatic pulse_filt(int w, int gap, string req);
    int n;
    @(negedge clk);
    n = cyc;
    pulse_raw = 1'b1;
    if (w >= Q) push(n + Q + 3, 1'b1, req);
    step(w);
    pulse_raw = 1'b0;
    if (w >= Q) push(n + w + Q + 3, 1'b0, req);
    step(gap);
  endtask

  task automatic pulse_byp(int w, int gap, string req);
    int n;
    @(negedge clk);
    n = cyc;
    pulse_raw = 1'b1;
    push(n + 3, 1'b1, req);
    step(w);
    pulse_raw = 1'b0;
    push(n + w + 3, 1'b0, req);
    step(gap);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    int m;
    step(3);
    chk(pulse_out == 1'b0, "R1 during reset", int'(pulse_out), 0);
    rst = 1'b0;
    step(20);
    chk(pulse_out == 1'b0, "R1 after reset", int'(pulse_out), 0);

    // R4/R5 boundary on a high pulse
    pulse_filt(Q, 2*Q, "R4 width Q passes");
    pulse_filt(Q - 1, 2*Q, "R5 width Q-1");
    chk(pulse_out == 1'b0, "R5 short high rejected", int'(pulse_out), 0);
    pulse_filt(3, 2*Q, "R5 width 3");
    drained("R4 R5 events");

    // R5 low dropouts inside a long high level
    @(negedge clk);
    n = cyc;
    pulse_raw = 1'b1;
    push(n + Q + 3, 1'b1, "R5 dropout rise");
    step(2*Q);
    pulse_raw = 1'b0;
    step(Q - 1);
    pulse_raw = 1'b1;
    step(Q + 6);
    chk(pulse_out == 1'b1, "R5 low dropout rejected", int'(pulse_out), 1);
    pulse_raw = 1'b0;
    push(cyc + Q + 3, 1'b0, "R5 dropout fall");
    step(2*Q);
    drained("R5 dropout events");

    // R6 interrupted bursts never accumulate
    for (int k = 0; k < 4; k++) begin
      pulse_raw = 1'b1;
      step(Q - 4);
      pulse_raw = 1'b0;
      step(2);
    end
    step(2*Q);
    chk(pulse_out == 1'b0, "R6 burst with short gaps", int'(pulse_out), 0);
    drained("R6 events");

    // R7 square wave with each phase exactly Q
    for (int k = 0; k < 4; k++) pulse_filt(Q, Q, "R7 square wave");
    step(2*Q);
    drained("R7 events");

    // R9 select switched away and back mid-qualification
    @(negedge clk);
    n = cyc;
    pulse_raw = 1'b1;
    step(5);
    debounce_en = 1'b0;
    push(n + 6, 1'b1, "R3 switch to bypass");
    step(3);
    debounce_en = 1'b1;
    push(n + 9, 1'b0, "R3 switch to filter");
    push(n + Q + 3, 1'b1, "R9 qualification kept");
    step(30);
    m = cyc;
    pulse_raw = 1'b0;
    push(m + Q + 3, 1'b0, "R9 fall");
    step(2*Q);
    drained("R9 events");

    // R2/R8 bypass: every edge, even one-cycle pulses
    debounce_en = 1'b0;
    step(4);
    pulse_byp(5, 6, "R2 bypass delay");
    for (int k = 0; k < 4; k++) pulse_byp(1, 1, "R8 one-cycle pulse");
    step(10);
    drained("R2 R8 events");

    // R1 reset while the output is high
    pulse_raw = 1'b1;
    push(cyc + 3, 1'b1, "R1 pre-reset rise");
    step(8);
    drained("R1 pre-reset");
    rst = 1'b1;
    pulse_raw = 1'b0;
    step(1);
    chk(pulse_out == 1'b0, "R1 mid-run reset", int'(pulse_out), 0);
    step(3);
    rst = 1'b0;
    step(10);
    chk(pulse_out == 1'b0, "R1 low after release", int'(pulse_out), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule